// File: doc/BRIEF.md
# Credit-Flow Network Interface Wrapper

This block wraps a self-timed processing core so that it can sit on a packet network that never drops or resends traffic. Packets arriving from the network land in an input FIFO, where the core reads them whenever it is ready. The core's results go into an output FIFO, which drains toward the network only while the wrapper holds credits granted by the downstream receiver. Each credit stands for one free packet slot at the receiver.

Credits arrive on their own channel, separate from the data. Each credit message carries a count that is added to the local credit counter. In the other direction, the wrapper counts the input slots the core frees. It reports them upstream in one credit message once the count reaches a programmable threshold, or once a programmable number of cycles has passed with a non-zero count. The core is held off while its input is empty, while the output FIFO is full, or while no credit is left. Processing therefore starts when data arrives and pauses when the downstream path is starved.

The credit counter starts at a parameterised value after reset, which should equal the receiver's FIFO depth. A configuration strobe can load a new value at any time. There are two sticky error flags. One reports a credit message that would push the counter past a configured ceiling. The other reports a packet offered while the input FIFO was full.

Top module: `cnw_wrap`

## Requirements
- R1: After reset all valid outputs and both error flags are low, both ready outputs facing the senders are high, and the credit counter holds INIT_CREDIT, so exactly INIT_CREDIT packets leave before more credit is needed.
- R2: A packet leaves on the network output only while the credit counter is non-zero. Each accepted packet consumes one credit. Packets leave in the order the core wrote them.
- R3: A credit message is always accepted (crd_in_ready_o is 1), and its count is added to the counter. When a packet leaves in the same cycle, the result is the old value plus the count minus one.
- R4: A credit message whose addition would exceed cfg_max_credit_i sets err_crd_ovf_o, which stays set until reset. The message's count is discarded, and only a packet sent in that cycle changes the counter.
- R5: A cycle with cfg_load_i high sets the counter to cfg_init_credit_i. This takes precedence over sends and credit messages in that cycle.
- R6: net_in_ready_o is low exactly while the input FIFO is full. A packet offered in that state is not stored and sets err_in_ovf_o, which stays set until reset.
- R7: core_in_valid_o is high only while the input FIFO holds data, the credit counter is non-zero and the output FIFO is not full.
- R8: Each packet the core reads adds one freed slot to an accumulator. When the accumulator reaches cfg_thresh_i, a credit message carrying the whole accumulated count is raised and the accumulator restarts from the reads that come after it.
- R9: If a non-zero accumulator stays below the threshold, a credit message carrying it is raised once cfg_timeout_i cycles have passed since its first slot was freed.
- R10: A raised credit message keeps its valid and count stable until crd_out_ready_i accepts it, and it never carries a zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| net_in_valid_i | input | 1 | Packet offered by the network |
| net_in_data_i | input | DW | Incoming packet |
| net_in_ready_o | output | 1 | Input FIFO has room |
| crd_out_valid_o | output | 1 | Credit message to the upstream sender |
| crd_out_count_o | output | CW | Freed slots reported by the message |
| crd_out_ready_i | input | 1 | Upstream accepts the credit message |
| core_in_valid_o | output | 1 | Packet available to the core |
| core_in_data_o | output | DW | Packet to the core |
| core_in_ready_i | input | 1 | Core takes the packet |
| core_out_valid_i | input | 1 | Core result offered |
| core_out_data_i | input | DW | Core result |
| core_out_ready_o | output | 1 | Output FIFO has room |
| net_out_valid_o | output | 1 | Packet offered to the network |
| net_out_data_o | output | DW | Outgoing packet |
| net_out_ready_i | input | 1 | Network accepts the packet |
| crd_in_valid_i | input | 1 | Credit message from downstream |
| crd_in_count_i | input | CW | Credits granted by the message |
| crd_in_ready_o | output | 1 | Always 1 |
| cfg_load_i | input | 1 | Load the credit counter |
| cfg_init_credit_i | input | CW | Value loaded by cfg_load_i |
| cfg_max_credit_i | input | CW | Credit ceiling |
| cfg_thresh_i | input | CW | Freed-slot count that triggers a credit message |
| cfg_timeout_i | input | TW | Cycles before a partial count is flushed |
| err_crd_ovf_o | output | 1 | Sticky credit overflow flag |
| err_in_ovf_o | output | 1 | Sticky input overflow flag |

## Verification
The assertions check on every cycle the rules that a single step can show: no packet leaves and the core is never offered data without credit, a same-cycle send and credit arrival nets out, a rejected credit message leaves the counter alone, the error flags stay set, and a pending credit message holds still. Other behaviour only the bench's scenarios can show, because it depends on counts built up over many cycles. That covers how many packets drain for a given grant, packet order end to end, whether the threshold or the timeout raises the message, and that a packet offered into a full input FIFO is really lost while the earlier ones survive.

// File: rtl/cnw_pkg.sv
package cnw_pkg;
  // index width for a storage of the given depth, never zero
  function automatic int unsigned cnw_aw(int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/cnw_fifo.sv
module cnw_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned AW   = cnw_pkg::cnw_aw(DEPTH);
  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem_q [DEPTH];
  logic [AW-1:0]   wr_q, rd_q;
  logic [CNTW-1:0] cnt_q;
  logic            do_push, do_pop;

  assign full_o  = (cnt_q == CNTW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wrap_inc(wr_q);
      if (do_pop)  rd_q <= wrap_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/cnw_tx_credit.sv
module cnw_tx_credit #(
  parameter int unsigned CW          = 5,
  parameter int unsigned INIT_CREDIT = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          send_i,
  input  logic          crd_valid_i,
  input  logic [CW-1:0] crd_count_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] max_i,
  output logic [CW-1:0] credit_o,
  output logic          ovf_o
);
  logic [CW-1:0] credit_q;
  logic [CW:0]   sum;
  logic          over;

  assign sum  = {1'b0, credit_q} + (crd_valid_i ? {1'b0, crd_count_i} : '0);
  assign over = crd_valid_i && (sum > {1'b0, max_i});
  assign credit_o = credit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_q <= CW'(INIT_CREDIT);
      ovf_o    <= 1'b0;
    end else begin
      if (load_i)     credit_q <= load_val_i;
      else if (over)  credit_q <= credit_q - CW'(send_i);
      else            credit_q <= sum[CW-1:0] - CW'(send_i);
      if (over) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cnw_rx_credit.sv
module cnw_rx_credit #(
  parameter int unsigned CW = 5,
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic [CW-1:0] thresh_i,
  input  logic [TW-1:0] timeout_i,
  input  logic          msg_ready_i,
  output logic          msg_valid_o,
  output logic [CW-1:0] msg_count_o
);
  logic [CW-1:0] acc_q;
  logic [TW-1:0] tmr_q;
  logic          fire, launch;

  assign fire   = (acc_q != '0) && ((acc_q >= thresh_i) || (tmr_q == timeout_i));
  assign launch = fire && !msg_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      tmr_q       <= '0;
      msg_valid_o <= 1'b0;
      msg_count_o <= '0;
    end else begin
      if (launch) begin
        msg_valid_o <= 1'b1;
        msg_count_o <= acc_q;
        acc_q       <= CW'(pop_i);
        tmr_q       <= '0;
      end else begin
        if (msg_valid_o && msg_ready_i) msg_valid_o <= 1'b0;
        acc_q <= acc_q + CW'(pop_i);
        if (acc_q == '0)            tmr_q <= '0;
        else if (tmr_q != timeout_i) tmr_q <= tmr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cnw_wrap.sv
module cnw_wrap #(
  parameter int unsigned DW          = 16,
  parameter int unsigned IN_DEPTH    = 8,
  parameter int unsigned OUT_DEPTH   = 8,
  parameter int unsigned CW          = 5,
  parameter int unsigned TW          = 8,
  parameter int unsigned INIT_CREDIT = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          net_in_valid_i,
  input  logic [DW-1:0] net_in_data_i,
  output logic          net_in_ready_o,
  output logic          crd_out_valid_o,
  output logic [CW-1:0] crd_out_count_o,
  input  logic          crd_out_ready_i,
  output logic          core_in_valid_o,
  output logic [DW-1:0] core_in_data_o,
  input  logic          core_in_ready_i,
  input  logic          core_out_valid_i,
  input  logic [DW-1:0] core_out_data_i,
  output logic          core_out_ready_o,
  output logic          net_out_valid_o,
  output logic [DW-1:0] net_out_data_o,
  input  logic          net_out_ready_i,
  input  logic          crd_in_valid_i,
  input  logic [CW-1:0] crd_in_count_i,
  output logic          crd_in_ready_o,
  input  logic          cfg_load_i,
  input  logic [CW-1:0] cfg_init_credit_i,
  input  logic [CW-1:0] cfg_max_credit_i,
  input  logic [CW-1:0] cfg_thresh_i,
  input  logic [TW-1:0] cfg_timeout_i,
  output logic          err_crd_ovf_o,
  output logic          err_in_ovf_o
);
  logic          in_full, in_empty, out_full, out_empty;
  logic          in_pop, out_pop, core_go;
  logic [CW-1:0] credit_cnt;

  assign net_in_ready_o   = !in_full;
  assign core_out_ready_o = !out_full;
  assign crd_in_ready_o   = 1'b1;
  assign core_go          = (credit_cnt != '0) && !out_full;
  assign core_in_valid_o  = !in_empty && core_go;
  assign in_pop           = core_in_valid_o && core_in_ready_i;
  assign net_out_valid_o  = !out_empty && (credit_cnt != '0);
  assign out_pop          = net_out_valid_o && net_out_ready_i;

  cnw_fifo #(.W(DW), .DEPTH(IN_DEPTH)) u_in_fifo (
    .clk_i, .rst_ni,
    .push_i (net_in_valid_i), .data_i (net_in_data_i),
    .pop_i  (in_pop),         .data_o (core_in_data_o),
    .full_o (in_full),        .empty_o(in_empty)
  );

  cnw_fifo #(.W(DW), .DEPTH(OUT_DEPTH)) u_out_fifo (
    .clk_i, .rst_ni,
    .push_i (core_out_valid_i), .data_i (core_out_data_i),
    .pop_i  (out_pop),          .data_o (net_out_data_o),
    .full_o (out_full),         .empty_o(out_empty)
  );

  cnw_tx_credit #(.CW(CW), .INIT_CREDIT(INIT_CREDIT)) u_tx_credit (
    .clk_i, .rst_ni,
    .send_i      (out_pop),
    .crd_valid_i (crd_in_valid_i),
    .crd_count_i (crd_in_count_i),
    .load_i      (cfg_load_i),
    .load_val_i  (cfg_init_credit_i),
    .max_i       (cfg_max_credit_i),
    .credit_o    (credit_cnt),
    .ovf_o       (err_crd_ovf_o)
  );

  cnw_rx_credit #(.CW(CW), .TW(TW)) u_rx_credit (
    .clk_i, .rst_ni,
    .pop_i       (in_pop),
    .thresh_i    (cfg_thresh_i),
    .timeout_i   (cfg_timeout_i),
    .msg_ready_i (crd_out_ready_i),
    .msg_valid_o (crd_out_valid_o),
    .msg_count_o (crd_out_count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        err_in_ovf_o <= 1'b0;
    else if (net_in_valid_i && in_full) err_in_ovf_o <= 1'b1;
  end
endmodule

// File: rtl/cnw_wrap_chk.sv
module cnw_wrap_chk #(
  parameter int unsigned CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          net_in_valid_i,
  input logic          net_in_ready_o,
  input logic          crd_out_valid_o,
  input logic [CW-1:0] crd_out_count_o,
  input logic          crd_out_ready_i,
  input logic          core_in_valid_o,
  input logic          net_out_valid_o,
  input logic          net_out_ready_i,
  input logic          crd_in_valid_i,
  input logic [CW-1:0] crd_in_count_i,
  input logic          cfg_load_i,
  input logic [CW-1:0] cfg_max_credit_i,
  input logic          err_crd_ovf_o,
  input logic          err_in_ovf_o,
  input logic [CW-1:0] credit_cnt
);
  logic          send;
  logic [CW:0]   wide_sum;
  assign send     = net_out_valid_o && net_out_ready_i;
  assign wide_sum = {1'b0, credit_cnt} + {1'b0, crd_in_count_i};

  // R2
  no_send_without_credit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    net_out_valid_o |-> credit_cnt != '0);

  // R7
  core_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_in_valid_o |-> credit_cnt != '0);

  // R3
  credit_net_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crd_in_valid_i && !cfg_load_i && wide_sum <= {1'b0, cfg_max_credit_i}) |=>
      credit_cnt == CW'($past(credit_cnt) + $past(crd_in_count_i) - CW'($past(send))));

  // R4
  credit_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crd_in_valid_i && !cfg_load_i && wide_sum > {1'b0, cfg_max_credit_i}) |=>
      (credit_cnt == CW'($past(credit_cnt) - CW'($past(send)))) && err_crd_ovf_o);

  // R4
  crd_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_crd_ovf_o |=> err_crd_ovf_o);

  // R6
  in_ovf_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (net_in_valid_i && !net_in_ready_o) |=> err_in_ovf_o);

  // R6
  in_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_in_ovf_o |=> err_in_ovf_o);

  // R10
  crd_msg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crd_out_valid_o && !crd_out_ready_i) |=> crd_out_valid_o && $stable(crd_out_count_o));

  // R10
  crd_msg_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crd_out_valid_o |-> crd_out_count_o != '0);
endmodule

bind cnw_wrap cnw_wrap_chk #(.CW(CW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .net_in_valid_i  (net_in_valid_i),
  .net_in_ready_o  (net_in_ready_o),
  .crd_out_valid_o (crd_out_valid_o),
  .crd_out_count_o (crd_out_count_o),
  .crd_out_ready_i (crd_out_ready_i),
  .core_in_valid_o (core_in_valid_o),
  .net_out_valid_o (net_out_valid_o),
  .net_out_ready_i (net_out_ready_i),
  .crd_in_valid_i  (crd_in_valid_i),
  .crd_in_count_i  (crd_in_count_i),
  .cfg_load_i      (cfg_load_i),
  .cfg_max_credit_i(cfg_max_credit_i),
  .err_crd_ovf_o   (err_crd_ovf_o),
  .err_in_ovf_o    (err_in_ovf_o),
  .credit_cnt      (credit_cnt)
);

// File: tb/cnw_wrap_test.sv
module cnw_wrap_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, IND = 4, OUTD = 4, CW = 4, TW = 8, INIT = 4;

  // table: loaded credit, packets written, packets expected out before regrant
  localparam int VEC_N = 6;
  localparam int VEC_C [VEC_N] = '{0, 2, 4, 1, 3, 4};
  localparam int VEC_P [VEC_N] = '{3, 3, 4, 1, 2, 0};
  localparam int VEC_E [VEC_N] = '{0, 2, 4, 1, 2, 0};

  logic clk = 0, rst_n = 0;
  logic net_in_valid = 0; logic [DW-1:0] net_in_data = '0; logic net_in_ready;
  logic crd_out_valid; logic [CW-1:0] crd_out_count; logic crd_out_ready = 1;
  logic core_in_valid; logic [DW-1:0] core_in_data; logic core_in_ready = 0;
  logic core_out_valid = 0; logic [DW-1:0] core_out_data = '0; logic core_out_ready;
  logic net_out_valid; logic [DW-1:0] net_out_data; logic net_out_ready = 0;
  logic crd_in_valid = 0; logic [CW-1:0] crd_in_count = '0; logic crd_in_ready;
  logic cfg_load = 0; logic [CW-1:0] cfg_init = '0;
  logic [CW-1:0] cfg_max = 4'd8, cfg_thresh = 4'd2; logic [TW-1:0] cfg_timeout = 8'd200;
  logic err_crd, err_in;

  int n_chk = 0, n_fail = 0, done = 0;
  int sent_cnt = 0, ord_err = 0, rd_cnt = 0, msg_cnt = 0;
  logic [DW-1:0] push_seq = '0, out_seq = '0, rd_last = '0;
  logic [CW-1:0] msg_last = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnw_wrap #(.DW(DW), .IN_DEPTH(IND), .OUT_DEPTH(OUTD), .CW(CW), .TW(TW), .INIT_CREDIT(INIT)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .net_in_valid_i(net_in_valid), .net_in_data_i(net_in_data), .net_in_ready_o(net_in_ready),
    .crd_out_valid_o(crd_out_valid), .crd_out_count_o(crd_out_count), .crd_out_ready_i(crd_out_ready),
    .core_in_valid_o(core_in_valid), .core_in_data_o(core_in_data), .core_in_ready_i(core_in_ready),
    .core_out_valid_i(core_out_valid), .core_out_data_i(core_out_data), .core_out_ready_o(core_out_ready),
    .net_out_valid_o(net_out_valid), .net_out_data_o(net_out_data), .net_out_ready_i(net_out_ready),
    .crd_in_valid_i(crd_in_valid), .crd_in_count_i(crd_in_count), .crd_in_ready_o(crd_in_ready),
    .cfg_load_i(cfg_load), .cfg_init_credit_i(cfg_init), .cfg_max_credit_i(cfg_max),
    .cfg_thresh_i(cfg_thresh), .cfg_timeout_i(cfg_timeout),
    .err_crd_ovf_o(err_crd), .err_in_ovf_o(err_in)
  );

  always @(posedge clk) begin
    if (net_out_valid && net_out_ready) begin
      if (net_out_data !== out_seq) ord_err++;
      out_seq <= out_seq + 1'b1;
      sent_cnt++;
    end
    if (core_in_valid && core_in_ready) begin rd_cnt++; rd_last <= core_in_data; end
    if (crd_out_valid && crd_out_ready) begin msg_cnt++; msg_last <= crd_out_count; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic core_push(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      core_out_valid = 1; core_out_data = push_seq;
      while (!core_out_ready) @(negedge clk);
      push_seq = push_seq + 1'b1;
    end
    @(negedge clk); core_out_valid = 0;
  endtask

  task automatic net_push(input logic [DW-1:0] d);
    @(negedge clk); net_in_valid = 1; net_in_data = d;
  endtask

  task automatic net_idle();
    @(negedge clk); net_in_valid = 0;
  endtask

  task automatic give_credit(input int n);
    @(negedge clk); crd_in_valid = 1; crd_in_count = CW'(n);
    @(negedge clk); crd_in_valid = 0;
  endtask

  task automatic load_credit(input int n);
    @(negedge clk); cfg_load = 1; cfg_init = CW'(n);
    @(negedge clk); cfg_load = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int s0, r0, m0;
    cyc(3); rst_n = 1; cyc(1);

    // R1 reset state
    chk(!net_out_valid && !crd_out_valid && !core_in_valid, "R1 valids idle", 1, 0);
    chk(!err_crd && !err_in, "R1 errors clear", {err_crd, err_in}, 0);
    chk(net_in_ready && core_out_ready && crd_in_ready, "R1 readies", 0, 1);
    net_out_ready = 1; s0 = sent_cnt;
    core_push(6); cyc(8);
    chk(sent_cnt - s0 == INIT, "R1 initial credit", sent_cnt - s0, INIT);
    give_credit(2); cyc(6);
    chk(sent_cnt - s0 == 6, "R1 drain", sent_cnt - s0, 6);

    // R2 R5 table of load/write/expect
    for (int v = 0; v < VEC_N; v++) begin
      net_out_ready = 0;
      load_credit(VEC_C[v]);
      s0 = sent_cnt;
      core_push(VEC_P[v]);
      net_out_ready = 1; cyc(10);
      chk(sent_cnt - s0 == VEC_E[v], "R5 loaded credit limits sends", sent_cnt - s0, VEC_E[v]);
      give_credit(4); cyc(10);
      chk(sent_cnt - s0 == VEC_P[v], "R2 regrant drains rest", sent_cnt - s0, VEC_P[v]);
    end

    // R3 same-cycle send and credit arrival
    net_out_ready = 0; load_credit(1); s0 = sent_cnt;
    core_push(4);
    @(negedge clk); net_out_ready = 1; crd_in_valid = 1; crd_in_count = 4'd2;
    @(negedge clk); crd_in_valid = 0;
    cyc(10);
    chk(sent_cnt - s0 == 3, "R3 send and credit net", sent_cnt - s0, 3);
    give_credit(1); cyc(6);
    chk(sent_cnt - s0 == 4, "R3 credit added", sent_cnt - s0, 4);

    // R4 credit overflow rejected
    net_out_ready = 0; load_credit(2); s0 = sent_cnt;
    core_push(4);
    chk(!err_crd, "R4 flag clear before", err_crd, 0);
    give_credit(7);
    chk(err_crd, "R4 overflow flag", err_crd, 1);
    net_out_ready = 1; cyc(10);
    chk(sent_cnt - s0 == 2, "R4 rejected message adds nothing", sent_cnt - s0, 2);
    give_credit(2); cyc(6);
    chk(sent_cnt - s0 == 4, "R4 later grant accepted", sent_cnt - s0, 4);
    chk(err_crd, "R4 flag sticky", err_crd, 1);
    chk(ord_err == 0, "R2 packet order", ord_err, 0);

    // R7 gating on credit, R8 threshold message
    r0 = rd_cnt; m0 = msg_cnt;
    net_push(8'h51); net_push(8'h52); net_idle(); cyc(1);
    chk(!core_in_valid, "R7 no credit holds core", core_in_valid, 0);
    load_credit(3);
    chk(core_in_valid, "R7 credit releases core", core_in_valid, 1);
    @(negedge clk); core_in_ready = 1;
    cyc(3); core_in_ready = 0;
    chk(rd_cnt - r0 == 2 && rd_last == 8'h52, "R7 core reads in order", rd_last, 8'h52);
    cyc(6);
    chk(msg_cnt - m0 == 1, "R8 one threshold message", msg_cnt - m0, 1);
    chk(msg_last == 4'd2, "R8 message count", msg_last, 2);

    // R9 timeout flush, R10 hold while not accepted
    cfg_thresh = 4'd4; cfg_timeout = 8'd5; crd_out_ready = 0; m0 = msg_cnt;
    net_push(8'h61); net_idle();
    @(negedge clk); core_in_ready = 1;
    @(negedge clk); core_in_ready = 0;
    cyc(3);
    chk(!crd_out_valid, "R9 no early message", crd_out_valid, 0);
    cyc(8);
    chk(crd_out_valid && crd_out_count == 4'd1, "R9 timeout message", crd_out_count, 1);
    cyc(3);
    chk(crd_out_valid && crd_out_count == 4'd1, "R10 message held", crd_out_count, 1);
    crd_out_ready = 1; cyc(2);
    chk(msg_cnt - m0 == 1 && !crd_out_valid, "R10 accepted once", msg_cnt - m0, 1);

    // R6 input overflow
    r0 = rd_cnt;
    for (int i = 0; i < IND; i++) net_push(DW'(8'hA0 + i));
    net_idle();
    chk(!net_in_ready, "R6 ready low when full", net_in_ready, 0);
    chk(!err_in, "R6 flag clear before", err_in, 0);
    net_push(8'hAF); net_idle();
    chk(err_in, "R6 overflow flag", err_in, 1);
    @(negedge clk); core_in_ready = 1; cyc(8); core_in_ready = 0;
    chk(rd_cnt - r0 == IND, "R6 extra packet not stored", rd_cnt - r0, IND);
    chk(rd_last == 8'hA3, "R6 last stored packet", rd_last, 8'hA3);
    chk(err_in, "R6 flag sticky", err_in, 1);

    finish_run();
  end
endmodule